// File: doc/BRIEF.md
# Address-masked GPIO port controller

An eight-pin general-purpose I/O port on a simple single-cycle register bus. Every pin is an input or an output, chosen by a direction register. The pad side gets an output-enable vector and an output-value vector. The port samples a pin-input vector through a two-stage synchronizer.

The data register is not at one address. It repeats across a window of 1 KB, and word-address bits [9:2] of each access act as a per-pin mask. A write changes only the pins whose mask bit is set. A read returns zero for every pin whose mask bit is clear. Software can therefore set or clear any group of pins in one bus cycle, with no read-modify-write sequence and no race against other code that drives different pins.

Above the window are two more registers. One is the direction register. The other is a plain read/write sense register with no behaviour behind it. Every other offset reads as zero and ignores writes.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the data, direction and sense registers are all zero, so every pin is an input, `pin_oe_o` is 0x00 and `pin_out_o` is 0x00.
- R2: A write to any offset from 0x000 to 0x3FF uses mask = address bits [9:2]. Data bit n takes write-data bit n where mask bit n is 1, and keeps its old value where mask bit n is 0.
- R3: A read from any offset from 0x000 to 0x3FF uses mask = address bits [9:2]. Read bit n is the effective value of pin n where mask bit n is 1, and 0 where mask bit n is 0.
- R4: The effective value of an output pin (direction bit 1) is its stored data bit. The effective value of an input pin (direction bit 0) is `pin_i` after two flops. A change on `pin_i` shows up in a read only after the second rising clock edge.
- R5: The direction register is at offset 0x400 and can be written and read back. `pin_oe_o` always equals it, and a 1 in bit n makes pin n an output.
- R6: The sense register is at offset 0x404 and can be written and read back. Writing it changes neither `pin_oe_o` nor `pin_out_o`.
- R7: `pin_out_o` always equals the stored data register. This holds for input pins too, so a value written to an input pin is kept and drives the pad once the pin becomes an output.
- R8: A read from an offset of 0x408 or above returns 0x00. A write to such an offset changes no register.
- R9: Address bits [1:0] take no part in decoding. Offsets 0x403 and 0x400 reach the same register.
- R10: A write takes effect at the rising edge where `sel_i` and `wr_i` are both 1. Read data is combinational while `sel_i` is 1 and `wr_i` is 0, and is 0x00 at all other times. Nothing is written while `sel_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the access cycle |
| pin_i | input | 8 | Asynchronous pad inputs |
| pin_oe_o | output | 8 | Pad output enables (1 = drive) |
| pin_out_o | output | 8 | Pad output values |

## Verification
Within one cycle, a masked data read has to merge two sources: the stored data for output pins, and the synchronizer output for input pins. A direction write changes which source each pin uses. The bench sets a mixed direction pattern while the pad inputs differ from the stored data. It then sweeps all 256 read masks. Each result is compared with a value the bench computes from its own model of the data, direction and pin state.

The bench also checks the edge at which the synchronizer hands a new pin value to the read path. It samples one clock edge before the new value is due and one edge after, and expects the old value and then the new one.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  typedef enum logic [1:0] {
    TGT_DATA  = 2'd0,
    TGT_DIR   = 2'd1,
    TGT_SENSE = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_mask_pkg::*;
#(
  parameter int PIN_W  = 8,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output tgt_e              tgt_o,
  output logic [PIN_W-1:0]  mask_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] DIR_WORD   = WORD_W'(1 << PIN_W);
  localparam logic [WORD_W-1:0] SENSE_WORD = WORD_W'((1 << PIN_W) + 1);

  logic [WORD_W-1:0] word;
  logic              unused_lsb;

  assign word       = addr_i[ADDR_W-1:2];
  assign unused_lsb = ^addr_i[1:0];
  assign mask_o     = addr_i[PIN_W+1:2];

  always_comb begin
    if (addr_i[ADDR_W-1:PIN_W+2] == '0) tgt_o = TGT_DATA;
    else if (word == DIR_WORD)          tgt_o = TGT_DIR;
    else if (word == SENSE_WORD)        tgt_o = TGT_SENSE;
    else                                tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '0;
      else         chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_mask_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  tgt_e             tgt_i,
  input  logic [PIN_W-1:0] mask_i,
  input  logic [PIN_W-1:0] wdata_i,
  output logic [PIN_W-1:0] data_o,
  output logic [PIN_W-1:0] dir_o,
  output logic [PIN_W-1:0] sense_o
);
  // per-bit enables on the data register implement the address mask
  for (genvar n = 0; n < PIN_W; n++) begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    data_o[n] <= 1'b0;
      else if (we_i && tgt_i == TGT_DATA && mask_i[n]) data_o[n] <= wdata_i[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o   <= '0;
      sense_o <= '0;
    end else if (we_i) begin
      if (tgt_i == TGT_DIR)   dir_o   <= wdata_i;
      if (tgt_i == TGT_SENSE) sense_o <= wdata_i;
    end
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int PIN_W  = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PIN_W-1:0]  wdata_i,
  output logic [PIN_W-1:0]  rdata_o,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [PIN_W-1:0]  pin_oe_o,
  output logic [PIN_W-1:0]  pin_out_o
);
  tgt_e             tgt;
  logic [PIN_W-1:0] mask, data_q, dir_q, sense_q, pin_sync, eff;

  gpio_addr_dec #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) dec_i (
    .addr_i (addr_i),
    .tgt_o  (tgt),
    .mask_o (mask)
  );

  gpio_in_sync #(.W(PIN_W), .STAGES(2)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio_reg_file #(.PIN_W(PIN_W)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sel_i & wr_i),
    .tgt_i   (tgt),
    .mask_i  (mask),
    .wdata_i (wdata_i),
    .data_o  (data_q),
    .dir_o   (dir_q),
    .sense_o (sense_q)
  );

  assign eff = (dir_q & data_q) | (~dir_q & pin_sync);

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      unique case (tgt)
        TGT_DATA:  rdata_o = mask & eff;
        TGT_DIR:   rdata_o = dir_q;
        TGT_SENSE: rdata_o = sense_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign pin_oe_o  = dir_q;
  assign pin_out_o = data_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int PIN_W  = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [PIN_W-1:0]  wdata_i,
  input logic [PIN_W-1:0]  rdata_o,
  input logic [PIN_W-1:0]  pin_oe_o,
  input logic [PIN_W-1:0]  pin_out_o
);
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(4 << PIN_W);

  logic [PIN_W-1:0] amask;
  logic             in_win, at_dir, at_unmapped, rd, wr;

  assign amask       = addr_i[PIN_W+1:2];
  assign in_win      = addr_i < WIN;
  assign at_dir      = addr_i[ADDR_W-1:2] == WIN[ADDR_W-1:2];
  assign at_unmapped = addr_i >= WIN + ADDR_W'(8);
  assign rd          = sel_i && !wr_i;
  assign wr          = sel_i && wr_i;

  assert_masked_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && in_win |=> ((pin_out_o ^ $past(pin_out_o)) & ~$past(amask)) == '0
                     && ((pin_out_o ^ $past(wdata_i)) & $past(amask)) == '0);

  assert_masked_read_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && in_win |-> (rdata_o & ~amask) == '0);

  assert_output_pin_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && in_win |-> ((rdata_o ^ pin_out_o) & pin_oe_o & amask) == '0);

  assert_dir_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && at_dir |=> pin_oe_o == $past(wdata_i));

  assert_unmapped_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && at_unmapped |=> $stable(pin_oe_o) && $stable(pin_out_o));

  assert_unmapped_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && at_unmapped |-> rdata_o == '0);

  assert_idle_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(pin_oe_o) && $stable(pin_out_o));

  assert_idle_rdata_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |-> rdata_o == '0);
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pin_oe_o  (pin_oe_o),
  .pin_out_o (pin_out_o)
);

// File: tb/gpio_mask_port_tb_top.sv
module gpio_mask_port_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o, pin_oe_o, pin_out_o;
  logic [7:0]  pin_i = '0;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] data_m = '0, dir_m = '0, sense_m = '0;
  logic [7:0] r;

  always #2 clk_i = ~clk_i;

  gpio_mask_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i),
    .pin_oe_o(pin_oe_o), .pin_out_o(pin_out_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
  endtask

  function automatic logic [7:0] eff_m();
    return (dir_m & data_m) | (~dir_m & pin_i);
  endfunction

  initial begin
    #(4 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1 oe", pin_oe_o, 8'h00);
    check("R1 out", pin_out_o, 8'h00);
    bus_rd(12'h3FC, r); check("R1 data", r, 8'h00);
    bus_rd(12'h400, r); check("R1 dir", r, 8'h00);
    bus_rd(12'h404, r); check("R1 sense", r, 8'h00);

    // R5 direction all outputs
    bus_wr(12'h400, 8'hFF); dir_m = 8'hFF;
    check("R5 oe", pin_oe_o, 8'hFF);
    bus_rd(12'h400, r); check("R5 readback", r, 8'hFF);

    // R2/R9/R7 masked write sweep, low address bits varied
    for (int m = 0; m < 256; m++) begin
      logic [7:0] w;
      w = 8'(m * 37 + 11) ^ 8'h5A;
      bus_wr({2'b00, 8'(m), 2'(m)}, w);
      data_m = (data_m & ~8'(m)) | (w & 8'(m));
      check("R2 R7 out", pin_out_o, data_m);
    end

    // R3 masked read sweep, all outputs
    for (int m = 0; m < 256; m++) begin
      bus_rd({2'b00, 8'(m), 2'(3 - m % 4)}, r);
      check("R3 read", r, 8'(m) & data_m);
    end

    // R4 synchronizer latency on input pins
    bus_wr(12'h400, 8'h00); dir_m = 8'h00;
    bus_wr(12'h3FC, 8'h00); data_m = 8'h00;
    @(negedge clk_i); pin_i = 8'hC3;
    bus_rd(12'h3FC, r); check("R4 one edge", r, 8'h00);
    bus_rd(12'h3FC, r); check("R4 two edges", r, 8'hC3);

    // R4/R3 mixed directions, pins differ from stored data
    bus_wr(12'h3FC, 8'h96); data_m = 8'h96;
    bus_wr(12'h400, 8'hA5); dir_m = 8'hA5;
    @(negedge clk_i); pin_i = 8'h3C;
    repeat (2) @(negedge clk_i);
    for (int m = 0; m < 256; m++) begin
      bus_rd({2'b00, 8'(m), 2'b00}, r);
      check("R4 mixed", r, 8'(m) & eff_m());
    end

    // R6 sense storage, no pad effect
    bus_wr(12'h404, 8'h5A); sense_m = 8'h5A;
    check("R6 oe", pin_oe_o, dir_m);
    check("R6 out", pin_out_o, data_m);
    bus_rd(12'h407, r); check("R6 readback R9", r, 8'h5A);

    // R7 write to input pins still stored and driven on out
    bus_wr(12'h400, 8'h0F); dir_m = 8'h0F;
    bus_wr(12'h3C0, 8'hF0); data_m = (data_m & 8'h0F) | 8'hF0;
    check("R7 out", pin_out_o, data_m);
    bus_wr(12'h400, 8'hFF); dir_m = 8'hFF;
    bus_rd(12'h3FC, r); check("R7 read after dir", r, data_m);

    // R8 unmapped offsets
    foreach (addr_i[i]) ;
    for (int k = 0; k < 5; k++) begin
      logic [11:0] a;
      a = (k == 0) ? 12'h408 : (k == 1) ? 12'h40C : (k == 2) ? 12'h800 :
          (k == 3) ? 12'hFFC : 12'h7F1;
      bus_wr(a, 8'h00);
      check("R8 oe", pin_oe_o, dir_m);
      check("R8 out", pin_out_o, data_m);
      bus_rd(a, r); check("R8 read", r, 8'h00);
    end
    bus_rd(12'h400, r); check("R8 dir kept", r, dir_m);
    bus_rd(12'h404, r); check("R8 sense kept", r, sense_m);

    // R10 no write while sel low, rdata zero when idle
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b1; addr_i = 12'h3FC; wdata_i = ~data_m;
    @(negedge clk_i);
    check("R10 no write", pin_out_o, data_m);
    check("R10 idle rdata", rdata_o, 8'h00);
    wr_i = 1'b0;
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = 12'h3FC; wdata_i = 8'h81;
    #1 check("R10 before edge", pin_out_o, data_m);
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0; data_m = 8'h81;
    check("R10 after edge", pin_out_o, 8'h81);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule